// File: doc/BRIEF.md
# Bridge Transaction Ownership Table

This block takes ownership of non-posted requests as they cross a bus bridge, in both directions. When a non-posted request is accepted, the block claims a free slot in that direction's table. It stores the requester ID, tag and expected completion size there. The request leaves with a requester ID built by the bridge and a tag equal to the slot index. When the completion comes back, its tag selects the slot. The completion leaves with the stored ID and tag, and the slot is freed.

Each direction also keeps a completion-space budget, so a request is held off until its completion data is sure to have room. Downstream posted writes need no slot and keep their fields. Only one of them may be outstanding until the downstream side reports it committed. Upstream requests reaching this block are non-posted only.

Requests arrive as decoded header fields with a valid/ready handshake. Forwarded requests and restored completions leave on the same cycle they are accepted.

Top module: `bridge_owner_table`

## Requirements
- R1: An accepted upstream non-posted request leaves with requester ID `{cfgSecBus, 8'h00}`, so the device and function fields are zero.
- R2: An accepted downstream non-posted request leaves with requester ID `{cfgPriBus, cfgPriDev, cfgPriFunc}`. The bus number is in bits 15:8, the device in bits 7:3 and the function in bits 2:0.
- R3: The outgoing tag of a non-posted request is the lowest-numbered free slot of that direction's 8-slot table, zero-extended to 8 bits.
- R4: A completion whose tag names an occupied slot is forwarded in the same cycle with the stored original requester ID and tag. The slot becomes free from the next cycle.
- R5: A downstream posted request leaves with its requester ID and tag unchanged, and it occupies no slot.
- R6: After a downstream posted request is accepted, ready stays low for further posted requests until a one-cycle `dnCommit` pulse. Non-posted requests are not affected by this hold.
- R7: Each direction starts with 64 units of completion space. A non-posted request whose size exceeds the remaining space sees ready low. A size exactly equal to the remaining space is accepted. Releasing a slot returns its stored size.
- R8: When all 8 slots of a direction are occupied, ready is low for non-posted requests of that direction.
- R9: A completion whose tag names a free slot, or whose value is 8 or more, raises the error output for that cycle. It produces no forwarded completion and leaves the slots and the space unchanged.
- R10: An allocation and a release in the same direction and the same cycle are both performed. The space changes by the released size minus the allocated size.
- R11: After reset, every slot is free, the space is full, no posted request is outstanding and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPriBus | input | 8 | Primary bus number |
| cfgPriDev | input | 5 | Bridge device number |
| cfgPriFunc | input | 3 | Bridge function number |
| cfgSecBus | input | 8 | Secondary bus number |
| upReqValid | input | 1 | Upstream non-posted request valid |
| upReqReady | output | 1 | Upstream request accepted |
| upReqId | input | 16 | Upstream original requester ID |
| upReqTag | input | 8 | Upstream original tag |
| upReqSize | input | 7 | Upstream expected completion size |
| upOutValid | output | 1 | Forwarded upstream request valid |
| upOutId | output | 16 | Forwarded upstream requester ID |
| upOutTag | output | 8 | Forwarded upstream tag |
| upCplValid | input | 1 | Completion for an upstream request |
| upCplTag | input | 8 | Tag of that completion |
| upCplOutValid | output | 1 | Restored completion valid |
| upCplOutId | output | 16 | Restored requester ID |
| upCplOutTag | output | 8 | Restored tag |
| upCplErr | output | 1 | Completion tag names no occupied slot |
| dnReqValid | input | 1 | Downstream request valid |
| dnReqReady | output | 1 | Downstream request accepted |
| dnReqPosted | input | 1 | Downstream request is posted |
| dnReqId | input | 16 | Downstream original requester ID |
| dnReqTag | input | 8 | Downstream original tag |
| dnReqSize | input | 7 | Downstream expected completion size |
| dnOutValid | output | 1 | Forwarded downstream request valid |
| dnOutId | output | 16 | Forwarded downstream requester ID |
| dnOutTag | output | 8 | Forwarded downstream tag |
| dnCommit | input | 1 | Outstanding posted request committed |
| dnCplValid | input | 1 | Completion for a downstream request |
| dnCplTag | input | 8 | Tag of that completion |
| dnCplOutValid | output | 1 | Restored completion valid |
| dnCplOutId | output | 16 | Restored requester ID |
| dnCplOutTag | output | 8 | Restored tag |
| dnCplErr | output | 1 | Completion tag names no occupied slot |

## Verification
In one direction, a new non-posted allocation and the release of an earlier slot can fall in the same cycle. The bench provokes this by filling the space to near exhaustion. It then presents a small request together with the completion for slot 0. It judges the outcome in three ways:
- the new tag is the lowest slot that was free before the release;
- the restored completion is correct;
- afterwards, a request one unit larger than the net remaining space stalls, while one of exactly that size passes and reuses slot 0.

// File: rtl/bot_pkg.sv
package bot_pkg;
  localparam int TBL_ENTRIES = 8;
  localparam int TBL_IDX_W   = $clog2(TBL_ENTRIES);
  localparam int ID_W        = 16;
  localparam int TAG_W       = 8;

  typedef struct packed {
    logic                 allocEn;
    logic [TBL_IDX_W-1:0] allocIdx;
    logic                 relEn;
    logic [TBL_IDX_W-1:0] relIdx;
  } tblStrobe_t;
endpackage

// File: rtl/bot_ctrl.sv
module bot_ctrl #(
  parameter int CPL_SPACE   = 64,
  parameter int SIZE_W      = 7,
  parameter int POSTED_GATE = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqPosted,
  input  logic [SIZE_W-1:0]           reqSize,
  output logic                        reqReady,
  input  logic                        cplValid,
  input  logic [bot_pkg::TAG_W-1:0]   cplTag,
  input  logic [SIZE_W-1:0]           relSize,
  input  logic                        commit,
  output logic                        cplHit,
  output logic                        cplErr,
  output bot_pkg::tblStrobe_t         strb
);
  import bot_pkg::*;
  localparam int ENT     = TBL_ENTRIES;
  localparam int IDXW    = TBL_IDX_W;
  localparam int SPACE_W = $clog2(CPL_SPACE + 1);

  logic [ENT-1:0]     usedMap, usedNext;
  logic [SPACE_W-1:0] space, spaceNext;
  logic               postedBusy;
  logic               anyFree, fits, isPosted, npAccept, postAccept, tagOk;
  logic [IDXW-1:0]    freeIdx, tagIdx;
  int                 spaceInt;

  // lowest free slot
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = ENT - 1; i >= 0; i--) begin
      if (!usedMap[i]) begin
        anyFree = 1'b1;
        freeIdx = IDXW'(i);
      end
    end
  end

  assign isPosted   = (POSTED_GATE != 0) && reqPosted;
  assign fits       = int'(reqSize) <= int'(space);
  assign reqReady   = isPosted ? !postedBusy : (anyFree && fits);
  assign npAccept   = reqValid && reqReady && !isPosted;
  assign postAccept = reqValid && reqReady && isPosted;

  assign tagIdx = cplTag[IDXW-1:0];
  assign tagOk  = (cplTag >> IDXW) == '0;
  assign cplHit = cplValid && tagOk && usedMap[tagIdx];
  assign cplErr = cplValid && !(tagOk && usedMap[tagIdx]);

  assign strb.allocEn  = npAccept;
  assign strb.allocIdx = freeIdx;
  assign strb.relEn    = cplHit;
  assign strb.relIdx   = tagIdx;

  always_comb begin
    usedNext = usedMap;
    if (cplHit)   usedNext[tagIdx]  = 1'b0;
    if (npAccept) usedNext[freeIdx] = 1'b1;
    spaceInt = int'(space);
    if (npAccept) spaceInt = spaceInt - int'(reqSize);
    if (cplHit)   spaceInt = spaceInt + int'(relSize);
    spaceNext = SPACE_W'(spaceInt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedMap    <= '0;
      space      <= SPACE_W'(CPL_SPACE);
      postedBusy <= 1'b0;
    end else begin
      usedMap <= usedNext;
      space   <= spaceNext;
      if (postAccept)  postedBusy <= 1'b1;
      else if (commit) postedBusy <= 1'b0;
    end
  end

  a_r7_no_overcommit: assert property (@(posedge clk) disable iff (!rstN)
    int'(space) <= CPL_SPACE);
  a_r7_short_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isPosted && int'(reqSize) > int'(space)) |-> !reqReady);
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ((&usedMap) && reqValid && !isPosted) |-> !reqReady);
  a_r9_err_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (cplErr && !npAccept) |=> (usedMap == $past(usedMap)) && (space == $past(space)));
  a_r6_posted_held: assert property (@(posedge clk) disable iff (!rstN)
    postAccept |=> postedBusy);
  a_r6_hold_until_commit: assert property (@(posedge clk) disable iff (!rstN)
    (postedBusy && !commit) |=> postedBusy);
  a_r10_net_update: assert property (@(posedge clk) disable iff (!rstN)
    (npAccept && cplHit) |=>
      int'(space) == int'($past(space)) - int'($past(reqSize)) + int'($past(relSize)));
endmodule

// File: rtl/bot_dp.sv
module bot_dp #(
  parameter int SIZE_W = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  bot_pkg::tblStrobe_t         strb,
  input  logic [bot_pkg::ID_W-1:0]    ownId,
  input  logic                        reqPosted,
  input  logic [bot_pkg::ID_W-1:0]    reqId,
  input  logic [bot_pkg::TAG_W-1:0]   reqTag,
  input  logic [SIZE_W-1:0]           reqSize,
  output logic [bot_pkg::ID_W-1:0]    outId,
  output logic [bot_pkg::TAG_W-1:0]   outTag,
  output logic [SIZE_W-1:0]           relSize,
  output logic [bot_pkg::ID_W-1:0]    cplOutId,
  output logic [bot_pkg::TAG_W-1:0]   cplOutTag
);
  import bot_pkg::*;
  localparam int ENT  = TBL_ENTRIES;
  localparam int IDXW = TBL_IDX_W;

  logic [ID_W-1:0]   origId   [ENT];
  logic [TAG_W-1:0]  origTag  [ENT];
  logic [SIZE_W-1:0] origSize [ENT];

  generate
    for (genvar g = 0; g < ENT; g++) begin : gSlot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          origId[g]   <= '0;
          origTag[g]  <= '0;
          origSize[g] <= '0;
        end else if (strb.allocEn && strb.allocIdx == IDXW'(g)) begin
          origId[g]   <= reqId;
          origTag[g]  <= reqTag;
          origSize[g] <= reqSize;
        end
      end
    end
  endgenerate

  assign outId     = reqPosted ? reqId  : ownId;
  assign outTag    = reqPosted ? reqTag : {{(TAG_W-IDXW){1'b0}}, strb.allocIdx};
  assign relSize   = origSize[strb.relIdx];
  assign cplOutId  = origId[strb.relIdx];
  assign cplOutTag = origTag[strb.relIdx];

  a_r10_distinct_slots: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocEn && strb.relEn) |-> strb.allocIdx != strb.relIdx);
  a_r4_slot_saved: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> origId[$past(strb.allocIdx)] == $past(reqId)
                  && origTag[$past(strb.allocIdx)] == $past(reqTag));
endmodule

// File: rtl/bridge_owner_table.sv
module bridge_owner_table #(
  parameter int CPL_SPACE = 64,
  parameter int SIZE_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cfgPriBus,
  input  logic [4:0]        cfgPriDev,
  input  logic [2:0]        cfgPriFunc,
  input  logic [7:0]        cfgSecBus,
  input  logic              upReqValid,
  output logic              upReqReady,
  input  logic [15:0]       upReqId,
  input  logic [7:0]        upReqTag,
  input  logic [SIZE_W-1:0] upReqSize,
  output logic              upOutValid,
  output logic [15:0]       upOutId,
  output logic [7:0]        upOutTag,
  input  logic              upCplValid,
  input  logic [7:0]        upCplTag,
  output logic              upCplOutValid,
  output logic [15:0]       upCplOutId,
  output logic [7:0]        upCplOutTag,
  output logic              upCplErr,
  input  logic              dnReqValid,
  output logic              dnReqReady,
  input  logic              dnReqPosted,
  input  logic [15:0]       dnReqId,
  input  logic [7:0]        dnReqTag,
  input  logic [SIZE_W-1:0] dnReqSize,
  output logic              dnOutValid,
  output logic [15:0]       dnOutId,
  output logic [7:0]        dnOutTag,
  input  logic              dnCommit,
  input  logic              dnCplValid,
  input  logic [7:0]        dnCplTag,
  output logic              dnCplOutValid,
  output logic [15:0]       dnCplOutId,
  output logic [7:0]        dnCplOutTag,
  output logic              dnCplErr
);
  bot_pkg::tblStrobe_t upStrb, dnStrb;
  logic [SIZE_W-1:0]   upRelSize, dnRelSize;
  logic [15:0]         upOwnId, dnOwnId;

  assign upOwnId = {cfgSecBus, 8'h00};
  assign dnOwnId = {cfgPriBus, cfgPriDev, cfgPriFunc};

  bot_ctrl #(.CPL_SPACE(CPL_SPACE), .SIZE_W(SIZE_W), .POSTED_GATE(0)) upCtrl (
    .clk(clk), .rstN(rstN), .reqValid(upReqValid), .reqPosted(1'b0),
    .reqSize(upReqSize), .reqReady(upReqReady), .cplValid(upCplValid),
    .cplTag(upCplTag), .relSize(upRelSize), .commit(1'b0),
    .cplHit(upCplOutValid), .cplErr(upCplErr), .strb(upStrb));

  bot_dp #(.SIZE_W(SIZE_W)) upDp (
    .clk(clk), .rstN(rstN), .strb(upStrb), .ownId(upOwnId), .reqPosted(1'b0),
    .reqId(upReqId), .reqTag(upReqTag), .reqSize(upReqSize),
    .outId(upOutId), .outTag(upOutTag), .relSize(upRelSize),
    .cplOutId(upCplOutId), .cplOutTag(upCplOutTag));

  bot_ctrl #(.CPL_SPACE(CPL_SPACE), .SIZE_W(SIZE_W), .POSTED_GATE(1)) dnCtrl (
    .clk(clk), .rstN(rstN), .reqValid(dnReqValid), .reqPosted(dnReqPosted),
    .reqSize(dnReqSize), .reqReady(dnReqReady), .cplValid(dnCplValid),
    .cplTag(dnCplTag), .relSize(dnRelSize), .commit(dnCommit),
    .cplHit(dnCplOutValid), .cplErr(dnCplErr), .strb(dnStrb));

  bot_dp #(.SIZE_W(SIZE_W)) dnDp (
    .clk(clk), .rstN(rstN), .strb(dnStrb), .ownId(dnOwnId), .reqPosted(dnReqPosted),
    .reqId(dnReqId), .reqTag(dnReqTag), .reqSize(dnReqSize),
    .outId(dnOutId), .outTag(dnOutTag), .relSize(dnRelSize),
    .cplOutId(dnCplOutId), .cplOutTag(dnCplOutTag));

  assign upOutValid = upReqValid && upReqReady;
  assign dnOutValid = dnReqValid && dnReqReady;
endmodule

// File: tb/bridge_owner_table_tb_top.sv
`timescale 1ns/1ps
module bridge_owner_table_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgPriBus = 8'h3C, cfgSecBus = 8'h42;
  logic [4:0] cfgPriDev = 5'h0B;
  logic [2:0] cfgPriFunc = 3'h5;
  logic upReqValid, upReqReady, upOutValid, upCplValid, upCplOutValid, upCplErr;
  logic [15:0] upReqId, upOutId, upCplOutId;
  logic [7:0] upReqTag, upOutTag, upCplTag, upCplOutTag;
  logic [6:0] upReqSize, dnReqSize;
  logic dnReqValid, dnReqReady, dnReqPosted, dnOutValid, dnCommit, dnCplValid, dnCplOutValid, dnCplErr;
  logic [15:0] dnReqId, dnOutId, dnCplOutId;
  logic [7:0] dnReqTag, dnOutTag, dnCplTag, dnCplOutTag;

  localparam logic [15:0] UP_OWN = 16'h4200;
  localparam logic [15:0] DN_OWN = 16'h3C5D;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bridge_owner_table dut_i (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    upReqValid = 0; upReqId = 0; upReqTag = 0; upReqSize = 0; upCplValid = 0; upCplTag = 0;
    dnReqValid = 0; dnReqPosted = 0; dnReqId = 0; dnReqTag = 0; dnReqSize = 0;
    dnCommit = 0; dnCplValid = 0; dnCplTag = 0;
  endtask

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  // request: up=1 upstream; expReady, expId, expTag on the forwarded side
  task automatic req(string r, bit up, bit posted, logic [15:0] id, logic [7:0] tag,
                     logic [6:0] size, bit expReady, logic [15:0] expId, logic [7:0] expTag);
    if (up) begin upReqValid = 1; upReqId = id; upReqTag = tag; upReqSize = size; end
    else begin dnReqValid = 1; dnReqPosted = posted; dnReqId = id; dnReqTag = tag; dnReqSize = size; end
    #2;
    chk(r, "ready", up ? upReqReady : dnReqReady, expReady);
    chk(r, "outValid", up ? upOutValid : dnOutValid, expReady);
    if (expReady) begin
      chk(r, "outId", up ? upOutId : dnOutId, expId);
      chk(r, "outTag", up ? upOutTag : dnOutTag, expTag);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic cpl(string r, bit up, logic [7:0] tag, bit expHit,
                     logic [15:0] expId, logic [7:0] expTag);
    if (up) begin upCplValid = 1; upCplTag = tag; end
    else begin dnCplValid = 1; dnCplTag = tag; end
    #2;
    chk(r, "cplOutValid", up ? upCplOutValid : dnCplOutValid, expHit);
    chk(r, "cplErr", up ? upCplErr : dnCplErr, !expHit);
    if (expHit) begin
      chk(r, "cplOutId", up ? upCplOutId : dnCplOutId, expId);
      chk(r, "cplOutTag", up ? upCplOutTag : dnCplOutTag, expTag);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic tReset();
    doReset();
    #2;
    chk("R11", "upReady", upReqReady, 1);
    chk("R11", "dnReady", dnReqReady, 1);
    chk("R11", "upErr", upCplErr, 0);
    chk("R11", "dnCplValid", dnCplOutValid, 0);
    @(negedge clk);
  endtask

  task automatic tUpSubst();
    doReset();
    req("R1", 1, 0, 16'h1234, 8'h55, 4, 1, UP_OWN, 8'd0);
    req("R3", 1, 0, 16'h2222, 8'h66, 4, 1, UP_OWN, 8'd1);
    cpl("R4", 1, 8'd0, 1, 16'h1234, 8'h55);
    req("R3_reuse", 1, 0, 16'h3333, 8'h01, 4, 1, UP_OWN, 8'd0);
    cpl("R4", 1, 8'd1, 1, 16'h2222, 8'h66);
  endtask

  task automatic tDnSubst();
    doReset();
    req("R2", 0, 0, 16'h0102, 8'h09, 2, 1, DN_OWN, 8'd0);
    cpl("R4", 0, 8'd0, 1, 16'h0102, 8'h09);
    req("R4_freed", 0, 0, 16'h0103, 8'h0A, 2, 1, DN_OWN, 8'd0);
  endtask

  task automatic tPosted();
    doReset();
    req("R5", 0, 1, 16'hABCD, 8'h77, 0, 1, 16'hABCD, 8'h77);
    req("R6_hold", 0, 1, 16'hABCE, 8'h78, 0, 0, 16'h0, 8'h0);
    req("R5_noslot", 0, 0, 16'h1111, 8'h22, 3, 1, DN_OWN, 8'd0);
    dnCommit = 1;
    @(negedge clk);
    idle();
    req("R6_release", 0, 1, 16'hABCE, 8'h78, 0, 1, 16'hABCE, 8'h78);
  endtask

  task automatic tFull();
    doReset();
    for (int i = 0; i < 8; i++)
      req("R8_fill", 1, 0, 16'h0500 + 16'(i), 8'(i + 16), 1, 1, UP_OWN, 8'(i));
    req("R8", 1, 0, 16'h0600, 8'h30, 1, 0, 16'h0, 8'h0);
    cpl("R4", 1, 8'd5, 1, 16'h0505, 8'd21);
    req("R3_hole", 1, 0, 16'h0601, 8'h31, 1, 1, UP_OWN, 8'd5);
  endtask

  task automatic tSpace();
    doReset();
    req("R7", 0, 0, 16'h0A00, 8'h01, 40, 1, DN_OWN, 8'd0);
    req("R7_stall", 0, 0, 16'h0A01, 8'h02, 30, 0, 16'h0, 8'h0);
    cpl("R7", 0, 8'd0, 1, 16'h0A00, 8'h01);
    req("R7_back", 0, 0, 16'h0A01, 8'h02, 30, 1, DN_OWN, 8'd0);
    req("R7_exact", 0, 0, 16'h0A02, 8'h03, 34, 1, DN_OWN, 8'd1);
    req("R7_empty", 0, 0, 16'h0A03, 8'h04, 1, 0, 16'h0, 8'h0);
  endtask

  task automatic tBadTag();
    doReset();
    req("R9_setup", 1, 0, 16'hBEEF, 8'h10, 10, 1, UP_OWN, 8'd0);
    cpl("R9", 1, 8'd3, 0, 16'h0, 8'h0);
    cpl("R9_range", 1, 8'h80, 0, 16'h0, 8'h0);
    cpl("R9_again", 1, 8'd3, 0, 16'h0, 8'h0);
    req("R9_state", 1, 0, 16'hCAFE, 8'h11, 54, 1, UP_OWN, 8'd1);
    cpl("R9_kept", 1, 8'd0, 1, 16'hBEEF, 8'h10);
  endtask

  task automatic tSameCycle();
    doReset();
    req("R10_setup", 1, 0, 16'h7000, 8'hA0, 30, 1, UP_OWN, 8'd0);
    req("R10_setup", 1, 0, 16'h7001, 8'hA1, 30, 1, UP_OWN, 8'd1);
    upReqValid = 1; upReqId = 16'h7002; upReqTag = 8'hA2; upReqSize = 4;
    upCplValid = 1; upCplTag = 8'd0;
    #2;
    chk("R10", "ready", upReqReady, 1);
    chk("R10", "outTag", upOutTag, 2);
    chk("R10", "cplOutValid", upCplOutValid, 1);
    chk("R10", "cplOutId", upCplOutId, 16'h7000);
    chk("R10", "cplOutTag", upCplOutTag, 8'hA0);
    @(negedge clk);
    idle();
    req("R10_net", 1, 0, 16'h7003, 8'hA3, 31, 0, 16'h0, 8'h0);
    req("R10_net", 1, 0, 16'h7003, 8'hA3, 30, 1, UP_OWN, 8'd0);
  endtask

  initial begin
    idle();
    tReset();
    tUpSubst();
    tDnSubst();
    tPosted();
    tFull();
    tSpace();
    tBadTag();
    tSameCycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule